// File: doc/BRIEF.md
# Shader Node Sequencer

The sequencer steps a fragment program through its nodes and offers one instruction address at a time to two execution streams, texture and arithmetic. A program has one to four nodes. A small index field gives the position of the last node. The descriptors are packed toward the highest slot, so slot 3 always holds the final node and an N-node program occupies the top N slots. Each node first runs its texture group and then its ALU group. Every instruction address is the stream's master base plus the node's offset plus a running index. The index counts from zero up to the node's inclusive end value.

Each stream uses a valid/ready handshake, and an instruction counts as issued only when it is accepted. When the final ALU instruction of slot 3 is accepted, a single-cycle completion pulse follows. Before anything is issued, the descriptors are screened at start. A misplaced last-node marker, or a later node that has no texture group, makes the block raise a single-cycle fault pulse instead, and it issues nothing. The configuration inputs must stay stable while a program runs.

Top module: `frag_node_seq`

## Requirements
- R1: With last-node index n (0..3), the program runs slots 3-n, 4-n, ..., 3 in ascending order, and each active slot runs exactly once.
- R2: Inside a node, every texture instruction is accepted before the first ALU instruction. `alu_valid` stays low while any texture instruction of the current node has not been accepted.
- R3: For index i from 0 to the node's end value inclusive, the texture stream issues address `tex_base + tex_ofs[slot] + i` and the ALU stream issues address `alu_base + alu_ofs[slot] + i`, both taken modulo 2^AW.
- R4: A slot whose texture-enable bit is 0 goes straight to its ALU group. This is legal only for the first active slot.
- R5: While a valid is high and its ready is low, the valid stays high and the address does not change. An index advances only on acceptance. `tex_valid` and `alu_valid` are never high together.
- R6: `done` is high for exactly one cycle, the cycle right after the final ALU instruction of slot 3 is accepted.
- R7: Bit k of `node_last` marks slot k. A start is legal only if `node_last` equals 4'b1000 (only slot 3 marked). Otherwise `error` is high for one cycle, the cycle after start is sampled, and no instruction and no `done` are produced.
- R8: If an active slot above the first active slot has its texture-enable bit at 0, `error` is pulsed as in R7 and nothing is issued.
- R9: A start seen while a program is running is ignored. This holds even in the cycle in which the final ALU instruction is accepted.
- R10: While `rst_n` is low and in the first cycle after it is released, `tex_valid`, `alu_valid`, `done` and `error` are 0.
- R11: The offsets and ends held in inactive slots below the first active slot have no effect on the issued addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a program when idle |
| last_node | input | SW | Index of the last node (node count minus one) |
| tex_base | input | AW | Texture stream master offset |
| alu_base | input | AW | ALU stream master offset |
| node_tex_en | input | NODES | Per slot: node has a texture group |
| node_last | input | NODES | Per slot: last-node marker |
| node_tex_ofs | input | NODES*AW | Per slot texture offset, slot k at bits k*AW |
| node_tex_end | input | NODES*LW | Per slot index of the last texture instruction |
| node_alu_ofs | input | NODES*AW | Per slot ALU offset |
| node_alu_end | input | NODES*LW | Per slot index of the last ALU instruction |
| tex_ready | input | 1 | Texture unit accepts the offered address |
| tex_valid | output | 1 | Texture address offered |
| tex_addr | output | AW | Texture instruction address |
| alu_ready | input | 1 | ALU accepts the offered address |
| alu_valid | output | 1 | ALU address offered |
| alu_addr | output | AW | ALU instruction address |
| done | output | 1 | Program completed (one cycle) |
| error | output | 1 | Descriptor rule violated at start (one cycle) |

## Verification
A start request can arrive in the same cycle that the final ALU instruction of slot 3 is accepted. At that moment the sequencer is still busy, so the start has to be dropped. Otherwise the program would run a second time right after the completion pulse. The bench arranges this with both ready inputs held high. It counts the issue cycles of a known program and raises start exactly on the final acceptance edge. It then expects both valids to be low during the `done` cycle, only one completion over the following cycles, and no addresses beyond those of the single run.

// File: rtl/frag_seq_pkg.sv
// Shared types for the shader node sequencer.
// Assumes: consumers import the package before using phase_t.
package frag_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_TEX  = 2'd1,
        PH_ALU  = 2'd2
    } phase_t;
endpackage

// File: rtl/node_rule_chk.sv
// Screens the node descriptors against the program rules and works out
// the first active slot. Purely combinational.
// Assumes: NODES is a power of two, so last_node never exceeds NODES-1.
module node_rule_chk #(
    parameter int NODES = 4,
    parameter int SW    = $clog2(NODES)
) (
    input  logic [SW-1:0]    last_node,
    input  logic [NODES-1:0] node_tex_en,
    input  logic [NODES-1:0] node_last,
    output logic [SW-1:0]    first_slot,
    output logic             rules_ok
);
    localparam logic [NODES-1:0] TOP_MARK = {1'b1, {(NODES-1){1'b0}}};
    localparam logic [SW-1:0]    TOP_SLOT = SW'(NODES-1);

    // Right-justified layout: first slot sits last_node below the top slot.
    always_comb begin
        first_slot = TOP_SLOT - last_node;
    end

    // Marker must sit on the top slot only; later active slots need TEX ops.
    always_comb begin
        rules_ok = (node_last == TOP_MARK);
        for (int s = 0; s < NODES; s++) begin
            if ((SW'(s) > first_slot) && !node_tex_en[s]) begin
                rules_ok = 1'b0;
            end
        end
    end
endmodule

// File: rtl/node_addr_gen.sv
// Forms one stream's instruction address from master base, node offset
// and running index; wraps modulo 2^AW.
// Assumes: LW <= AW.
module node_addr_gen #(
    parameter int AW = 8,
    parameter int LW = 6
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] ofs,
    input  logic [LW-1:0] idx,
    output logic [AW-1:0] addr
);
    // Three-term sum truncated to the address width.
    always_comb begin
        addr = base + ofs + AW'(idx);
    end
endmodule

// File: rtl/node_seq_fsm.sv
// Walks the active slots from the first to the top one; per slot runs the
// texture group, then the ALU group, advancing only on accepted handshakes.
// Assumes: descriptor inputs are held stable while a program is running.
module node_seq_fsm
    import frag_seq_pkg::*;
#(
    parameter int NODES = 4,
    parameter int LW    = 6,
    parameter int SW    = $clog2(NODES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               rules_ok,
    input  logic [SW-1:0]      first_slot,
    input  logic [NODES-1:0]   node_tex_en,
    input  logic [NODES*LW-1:0] node_tex_end,
    input  logic [NODES*LW-1:0] node_alu_end,
    input  logic               tex_ready,
    input  logic               alu_ready,
    output logic               tex_valid,
    output logic               alu_valid,
    output logic [SW-1:0]      slot,
    output logic [LW-1:0]      idx,
    output logic               done,
    output logic               error
);
    localparam logic [SW-1:0] TOP_SLOT = SW'(NODES-1);

    phase_t       phase;
    logic [LW-1:0] tex_end_cur;
    logic [LW-1:0] alu_end_cur;

    // Select the end fields of the slot being executed.
    always_comb begin
        tex_end_cur = node_tex_end[int'(slot)*LW +: LW];
        alu_end_cur = node_alu_end[int'(slot)*LW +: LW];
    end

    // Offer strobes follow the phase register directly.
    always_comb begin
        tex_valid = (phase == PH_TEX);
        alu_valid = (phase == PH_ALU);
    end

    // Phase, slot and index sequencing with one-cycle done/error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            slot  <= '0;
            idx   <= '0;
            done  <= 1'b0;
            error <= 1'b0;
        end else begin
            done  <= 1'b0;
            error <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        if (!rules_ok) begin
                            error <= 1'b1;
                        end else begin
                            slot  <= first_slot;
                            idx   <= '0;
                            phase <= node_tex_en[first_slot] ? PH_TEX : PH_ALU;
                        end
                    end
                end
                PH_TEX: begin
                    if (tex_ready) begin
                        if (idx == tex_end_cur) begin
                            idx   <= '0;
                            phase <= PH_ALU;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                PH_ALU: begin
                    if (alu_ready) begin
                        if (idx == alu_end_cur) begin
                            idx <= '0;
                            if (slot == TOP_SLOT) begin
                                phase <= PH_IDLE;
                                done  <= 1'b1;
                            end else begin
                                slot  <= slot + 1'b1;
                                phase <= PH_TEX;
                            end
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/frag_node_seq.sv
// Top of the shader node sequencer: rule screening, sequencing control and
// one address generator per instruction stream.
// Assumes: configuration inputs stable from start until done.
module frag_node_seq #(
    parameter int AW    = 8,
    parameter int LW    = 6,
    parameter int NODES = 4,
    parameter int SW    = $clog2(NODES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [SW-1:0]       last_node,
    input  logic [AW-1:0]       tex_base,
    input  logic [AW-1:0]       alu_base,
    input  logic [NODES-1:0]    node_tex_en,
    input  logic [NODES-1:0]    node_last,
    input  logic [NODES*AW-1:0] node_tex_ofs,
    input  logic [NODES*LW-1:0] node_tex_end,
    input  logic [NODES*AW-1:0] node_alu_ofs,
    input  logic [NODES*LW-1:0] node_alu_end,
    input  logic                tex_ready,
    output logic                tex_valid,
    output logic [AW-1:0]       tex_addr,
    input  logic                alu_ready,
    output logic                alu_valid,
    output logic [AW-1:0]       alu_addr,
    output logic                done,
    output logic                error
);
    logic [SW-1:0] first_slot;
    logic          rules_ok;
    logic [SW-1:0] slot;
    logic [LW-1:0] idx;
    logic [AW-1:0] tex_ofs_cur;
    logic [AW-1:0] alu_ofs_cur;

    node_rule_chk #(.NODES(NODES), .SW(SW)) u_rules (
        .last_node  (last_node),
        .node_tex_en(node_tex_en),
        .node_last  (node_last),
        .first_slot (first_slot),
        .rules_ok   (rules_ok)
    );

    node_seq_fsm #(.NODES(NODES), .LW(LW), .SW(SW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .rules_ok    (rules_ok),
        .first_slot  (first_slot),
        .node_tex_en (node_tex_en),
        .node_tex_end(node_tex_end),
        .node_alu_end(node_alu_end),
        .tex_ready   (tex_ready),
        .alu_ready   (alu_ready),
        .tex_valid   (tex_valid),
        .alu_valid   (alu_valid),
        .slot        (slot),
        .idx         (idx),
        .done        (done),
        .error       (error)
    );

    // Offsets of the slot currently being executed.
    always_comb begin
        tex_ofs_cur = node_tex_ofs[int'(slot)*AW +: AW];
        alu_ofs_cur = node_alu_ofs[int'(slot)*AW +: AW];
    end

    node_addr_gen #(.AW(AW), .LW(LW)) u_tex_addr (
        .base(tex_base),
        .ofs (tex_ofs_cur),
        .idx (idx),
        .addr(tex_addr)
    );

    node_addr_gen #(.AW(AW), .LW(LW)) u_alu_addr (
        .base(alu_base),
        .ofs (alu_ofs_cur),
        .idx (idx),
        .addr(alu_addr)
    );
endmodule

// File: rtl/frag_node_seq_chk.sv
// Port-level protocol checks for the shader node sequencer, bound to the top.
module frag_node_seq_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          tex_ready,
    input logic          tex_valid,
    input logic [AW-1:0] tex_addr,
    input logic          alu_ready,
    input logic          alu_valid,
    input logic [AW-1:0] alu_addr,
    input logic          done,
    input logic          error
);
    // R5
    streams_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tex_valid && alu_valid));
    // R5
    tex_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tex_valid && !tex_ready) |=> (tex_valid && $stable(tex_addr)));
    // R5
    alu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_valid && !alu_ready) |=> (alu_valid && $stable(alu_addr)));
    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6
    done_follows_alu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(alu_valid && alu_ready));
    // R7
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (!tex_valid && !alu_valid && !done));
    // R7
    fault_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> $past(start));
    // R9
    idle_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!tex_valid && !alu_valid));
endmodule

bind frag_node_seq frag_node_seq_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tex_ready(tex_ready),
    .tex_valid(tex_valid),
    .tex_addr (tex_addr),
    .alu_ready(alu_ready),
    .alu_valid(alu_valid),
    .alu_addr (alu_addr),
    .done     (done),
    .error    (error)
);

// File: tb/frag_node_seq_test.sv
module frag_node_seq_test;
    localparam int AW = 8;
    localparam int LW = 6;
    localparam int NODES = 4;
    localparam int SW = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, start;
    logic [SW-1:0] last_node;
    logic [AW-1:0] tex_base, alu_base;
    logic [NODES-1:0] t_en, l_flag;
    logic [AW-1:0] t_ofs [NODES];
    logic [AW-1:0] a_ofs [NODES];
    logic [LW-1:0] t_end [NODES];
    logic [LW-1:0] a_end [NODES];
    logic [NODES*AW-1:0] node_tex_ofs, node_alu_ofs;
    logic [NODES*LW-1:0] node_tex_end, node_alu_end;
    logic tex_ready, alu_ready, tex_valid, alu_valid, done, error;
    logic [AW-1:0] tex_addr, alu_addr;

    for (genvar g = 0; g < NODES; g++) begin : g_pack
        assign node_tex_ofs[g*AW +: AW] = t_ofs[g];
        assign node_alu_ofs[g*AW +: AW] = a_ofs[g];
        assign node_tex_end[g*LW +: LW] = t_end[g];
        assign node_alu_end[g*LW +: LW] = a_end[g];
    end

    frag_node_seq #(.AW(AW), .LW(LW), .NODES(NODES), .SW(SW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .last_node(last_node),
        .tex_base(tex_base), .alu_base(alu_base),
        .node_tex_en(t_en), .node_last(l_flag),
        .node_tex_ofs(node_tex_ofs), .node_tex_end(node_tex_end),
        .node_alu_ofs(node_alu_ofs), .node_alu_end(node_alu_end),
        .tex_ready(tex_ready), .tex_valid(tex_valid), .tex_addr(tex_addr),
        .alu_ready(alu_ready), .alu_valid(alu_valid), .alu_addr(alu_addr),
        .done(done), .error(error)
    );

    int nchk = 0, nfail = 0;
    int cyc = 0;
    int log_n, exp_n, done_cnt, err_cnt, both_cnt, alu_seen;
    int last_alu_cyc, done_cyc, err_cyc, start_cyc;
    bit log_k [512];
    logic [AW-1:0] log_a [512];
    bit exp_k [512];
    logic [AW-1:0] exp_a [512];
    int ready_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    // Ready generation: 0 = always ready, 1 = pseudo-random, 2 = texture stalled.
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (ready_mode)
            1: begin tex_ready = lfsr[0]; alu_ready = lfsr[3]; end
            2: begin tex_ready = 1'b0; alu_ready = 1'b1; end
            default: begin tex_ready = 1'b1; alu_ready = 1'b1; end
        endcase
    end

    // Monitor: logs accepted instructions and pulse cycles.
    always @(posedge clk) begin
        cyc++;
        if (rst_n) begin
            if (tex_valid && tex_ready && log_n < 512) begin
                log_k[log_n] = 1'b0; log_a[log_n] = tex_addr; log_n++;
            end
            if (alu_valid && alu_ready && log_n < 512) begin
                log_k[log_n] = 1'b1; log_a[log_n] = alu_addr; log_n++;
                last_alu_cyc = cyc;
            end
            if (done) begin done_cnt++; done_cyc = cyc; end
            if (error) begin err_cnt++; err_cyc = cyc; end
            if (start) start_cyc = cyc;
            if (tex_valid && alu_valid) both_cnt++;
            if (alu_valid) alu_seen++;
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_cfg();
        last_node = '0; tex_base = '0; alu_base = '0;
        t_en = '0; l_flag = 4'b1000;
        for (int s = 0; s < NODES; s++) begin
            t_ofs[s] = '0; a_ofs[s] = '0; t_end[s] = '0; a_end[s] = '0;
        end
    endtask

    task automatic clear_log();
        log_n = 0; done_cnt = 0; err_cnt = 0; both_cnt = 0; alu_seen = 0;
    endtask

    // Expected issue list from R1..R4: active slots only, TEX then ALU per slot.
    task automatic build_exp();
        int first;
        first = 3 - int'(last_node);
        exp_n = 0;
        for (int s = first; s < NODES; s++) begin
            if (t_en[s]) begin
                for (int i = 0; i <= int'(t_end[s]); i++) begin
                    exp_k[exp_n] = 1'b0;
                    exp_a[exp_n] = AW'(int'(tex_base) + int'(t_ofs[s]) + i);
                    exp_n++;
                end
            end
            for (int i = 0; i <= int'(a_end[s]); i++) begin
                exp_k[exp_n] = 1'b1;
                exp_a[exp_n] = AW'(int'(alu_base) + int'(a_ofs[s]) + i);
                exp_n++;
            end
        end
    endtask

    task automatic cmp_log(string req);
        chk(log_n == exp_n, {req, " count"}, log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            chk(log_k[i] == exp_k[i] && log_a[i] == exp_a[i], req,
                int'(log_k[i]) * 256 + int'(log_a[i]),
                int'(exp_k[i]) * 256 + int'(exp_a[i]));
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic run_prog();
        pulse_start();
        for (int k = 0; k < 3000 && done_cnt == 0 && err_cnt == 0; k++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // R10: idle outputs during and right after reset.
    task automatic t_reset();
        chk(!tex_valid && !alu_valid && !done && !error, "R10 in reset",
            int'({tex_valid, alu_valid, done, error}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tex_valid && !alu_valid && !done && !error, "R10 after release",
            int'({tex_valid, alu_valid, done, error}), 0);
    endtask

    // R1 R4 R6: single node without texture group.
    task automatic t_single();
        clear_cfg(); clear_log(); ready_mode = 0;
        alu_base = 8'h20; a_ofs[3] = 8'h05; a_end[3] = 6'd2;
        build_exp(); run_prog();
        cmp_log("R4 single node ALU only");
        chk(done_cnt == 1, "R6 done count", done_cnt, 1);
        chk(done_cyc == last_alu_cyc + 1, "R6 done timing", done_cyc, last_alu_cyc + 1);
        chk(err_cnt == 0, "R1 no error", err_cnt, 0);
    endtask

    // R1 R2 R3: four nodes, all with texture groups.
    task automatic t_four();
        clear_cfg(); clear_log(); ready_mode = 0;
        last_node = 2'd3; tex_base = 8'h40; alu_base = 8'h80; t_en = 4'b1111;
        for (int s = 0; s < NODES; s++) begin
            t_ofs[s] = AW'(s * 7); t_end[s] = LW'(s % 3);
            a_ofs[s] = AW'(s * 11 + 1); a_end[s] = LW'((s + 1) % 3);
        end
        build_exp(); run_prog();
        cmp_log("R1 four-node order");
        chk(done_cnt == 1, "R6 four-node done", done_cnt, 1);
        chk(both_cnt == 0, "R5 streams exclusive", both_cnt, 0);
    endtask

    // R5 R11: two nodes under random backpressure, garbage in inactive slots.
    task automatic t_two_bp();
        clear_cfg(); clear_log(); ready_mode = 1;
        last_node = 2'd1; tex_base = 8'h10; alu_base = 8'h60;
        t_en = 4'b1100;
        t_ofs[0] = 8'hAA; t_end[0] = 6'd9; a_ofs[0] = 8'h55; a_end[0] = 6'd7;
        t_ofs[1] = 8'h33; t_end[1] = 6'd5; a_ofs[1] = 8'h77; a_end[1] = 6'd4;
        t_ofs[2] = 8'h02; t_end[2] = 6'd3; a_ofs[2] = 8'h08; a_end[2] = 6'd1;
        t_ofs[3] = 8'h09; t_end[3] = 6'd1; a_ofs[3] = 8'h0C; a_end[3] = 6'd4;
        build_exp(); run_prog();
        ready_mode = 0;
        cmp_log("R11 inactive slots ignored");
        chk(both_cnt == 0, "R5 exclusive under backpressure", both_cnt, 0);
        chk(done_cnt == 1, "R5 backpressure done", done_cnt, 1);
    endtask

    // R2 R5: texture stalled; ALU must wait, address must hold.
    task automatic t_stall();
        clear_cfg(); clear_log();
        @(negedge clk) ready_mode = 2;
        tex_base = 8'h30; t_en = 4'b1000; t_ofs[3] = 8'h04; t_end[3] = 6'd1;
        alu_base = 8'h90; a_end[3] = 6'd1;
        build_exp();
        pulse_start();
        repeat (20) @(negedge clk);
        chk(alu_seen == 0, "R2 ALU held back", alu_seen, 0);
        chk(tex_valid && tex_addr == 8'h34, "R5 stalled address",
            int'({tex_valid, tex_addr}), 256 + 8'h34);
        ready_mode = 0;
        for (int k = 0; k < 100 && done_cnt == 0; k++) @(negedge clk);
        cmp_log("R2 stall sequence");
    endtask

    // R3: address wrap modulo 2^AW.
    task automatic t_wrap();
        clear_cfg(); clear_log(); ready_mode = 0;
        tex_base = 8'hF0; t_en = 4'b1000; t_ofs[3] = 8'h0E; t_end[3] = 6'd3;
        alu_base = 8'hFF; a_ofs[3] = 8'h01; a_end[3] = 6'd0;
        build_exp(); run_prog();
        chk(exp_a[2] == 8'h00, "R3 wrap expectation", int'(exp_a[2]), 0);
        cmp_log("R3 address wrap");
    endtask

    // R7 R8: rule violations produce error, nothing issued.
    task automatic t_fault(string req, logic [SW-1:0] ln, logic [3:0] en, logic [3:0] lf);
        clear_cfg(); clear_log(); ready_mode = 0;
        last_node = ln; t_en = en; l_flag = lf;
        run_prog();
        chk(err_cnt == 1, {req, " error pulse"}, err_cnt, 1);
        chk(err_cyc == start_cyc + 1, {req, " error timing"}, err_cyc, start_cyc + 1);
        chk(log_n == 0, {req, " nothing issued"}, log_n, 0);
        chk(done_cnt == 0, {req, " no done"}, done_cnt, 0);
    endtask

    // R9: start coinciding with the final ALU acceptance is ignored.
    task automatic t_overlap();
        int total;
        clear_cfg(); clear_log(); ready_mode = 0;
        tex_base = 8'h01; t_en = 4'b1000; t_end[3] = 6'd1;
        alu_base = 8'h50; a_end[3] = 6'd2;
        build_exp();
        total = exp_n;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (total - 1) @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(done && !tex_valid && !alu_valid, "R9 idle in done cycle",
            int'({done, tex_valid, alu_valid}), 4);
        repeat (8) @(negedge clk);
        chk(done_cnt == 1, "R9 single completion", done_cnt, 1);
        cmp_log("R9 no rerun");
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; tex_ready = 1'b1; alu_ready = 1'b1;
        clear_cfg(); clear_log();
        repeat (3) @(negedge clk);
        t_reset();
        t_single();
        t_four();
        t_two_bp();
        t_stall();
        t_wrap();
        t_fault("R7 marker on slot 2", 2'd1, 4'b1100, 4'b0100);
        t_fault("R7 extra marker inactive slot", 2'd0, 4'b1000, 4'b1001);
        t_fault("R8 later node without TEX", 2'd2, 4'b1010, 4'b1000);
        t_single();
        t_overlap();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL R6 watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule